// File: doc/BRIEF.md
# Sprite Line Sequencer

This block runs once per scanline in a tile-and-sprite video processor. A start pulse makes it read the 32-entry sprite attribute table from video RAM and work out how many sprites are live. It then draws every live sprite that crosses the current scanline into a line buffer, one pixel write per cycle. A done flag reports that the line buffer holds the finished sprite layer for that line.

The work is split into two passes. The first pass walks forward from sprite 0. It stops at the first entry whose vertical byte is the end-of-list marker 0xD0, or after sprite 31. The second pass walks back down from the last live sprite to sprite 0, and each sprite overwrites what was drawn before it. Sprite 0 is therefore written last, so it always shows in front of the higher-numbered sprites. Video RAM is read one byte at a time through a request/valid handshake with any latency.

Top module: `sprite_line_seq`

## Requirements
- R1: After reset, `done`, `vram_req` and `lb_we` are all low until a start pulse is accepted.
- R2: The counting pass reads the vertical byte of sprite i at `sat_base + 4*i`, for i = 0, 1, 2 and so on. It stops at the first byte equal to 0xD0 or after sprite 31, so up to 32 sprites can be live. The first read after a start is at `sat_base`.
- R3: When sprite 0's vertical byte is 0xD0, nothing is written to the line buffer, whatever the rest of the table holds.
- R4: Live sprites are drawn from the highest live number down to sprite 0. Where sprites overlap, the pixel from the lowest-numbered sprite is the one left in the line buffer.
- R5: The terminating sprite and every sprite numbered above it are never drawn.
- R6: An entry holds the vertical byte, the horizontal byte, the pattern number and the colour, at offsets 0 to 3. A sprite is drawn on scanline L only when row = (L - y - 1) mod 256 is less than 8.
- R7: The pattern byte is read from `pat_base + 8*pattern + row`. Bit 7 is the pixel at x and bit 0 is the pixel at x+7. Only set bits are written.
- R8: The colour is the low 4 bits of the colour byte. Colour 0 is transparent, and a sprite with colour 0 writes nothing.
- R9: A pixel whose position x+k is beyond 255 is dropped. It does not wrap to the left edge.
- R10: When the count is zero, `done` rises the cycle after entry 0's read returns. Otherwise `done` rises the cycle after sprite 0's eighth pixel slot, or after its visibility check if it is not drawn. It stays high until the next accepted start.
- R11: While `vram_req` is high and `vram_valid` is low, `vram_req` stays high and `vram_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a scanline; taken only when the sequencer is idle |
| scanline | input | 8 | Scanline number, captured with start |
| sat_base | input | VA_W | Video RAM address of the attribute table |
| pat_base | input | VA_W | Video RAM address of the sprite pattern table |
| vram_req | output | 1 | Read request |
| vram_addr | output | VA_W | Read address |
| vram_data | input | 8 | Read data, valid with vram_valid |
| vram_valid | input | 1 | One-cycle strobe that completes the pending read |
| lb_we | output | 1 | Line buffer write enable |
| lb_addr | output | 8 | Line buffer pixel position |
| lb_color | output | COL_W | Pixel colour |
| done | output | 1 | Sprite layer for the line is complete |

## Verification
Random tables are generated with a random or absent terminator and vertical positions clustered around the scanline. These separate the counting limit, the row window and the draw order from each other, and the whole line buffer is compared with an independent model. Directed tables isolate single effects. Stacked opaque sprites on one spot show the priority order. A marker at entry 0 over a table of visible sprites shows the empty case. Rows −1, 0, 7 and 8 around the scanline, plus a sprite wrapping from y=255, show the window edges. A sparse 0x81 pattern shows the bit order, and a colour-0 sprite over an opaque one shows transparency. A sprite at x=252 shows clipping at the right edge. Done timing is measured against the last write or the last read.

// File: rtl/sls_pkg.sv
package sls_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CNT,
    ST_DY,
    ST_DX,
    ST_DN,
    ST_DC,
    ST_CHK,
    ST_PAT,
    ST_EMIT
  } seq_st_t;

  // Row of the sprite on the given line, modulo 256 (row 0 is the line after y).
  function automatic logic [7:0] row_of(input logic [7:0] line, input logic [7:0] ypos);
    return line - ypos - 8'd1;
  endfunction

  // Pixel position of slot k of a sprite whose left edge is x; bit 8 flags overflow.
  function automatic logic [8:0] pix_pos(input logic [7:0] x, input logic [2:0] k);
    return {1'b0, x} + {6'd0, k};
  endfunction

endpackage

// File: rtl/sls_ctrl.sv
module sls_ctrl
  import sls_pkg::*;
#(
  parameter int NSPR     = 32,
  parameter int VA_W     = 14,
  parameter int ROW_W    = 3,
  parameter logic [7:0] END_MARK = 8'hD0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [VA_W-1:0]    sat_base,
  input  logic [VA_W-1:0]    pat_base,
  input  logic [7:0]         vram_data,
  input  logic               vram_valid,
  input  logic               draw_ok,
  input  logic [7:0]         pat_name,
  input  logic [ROW_W-1:0]   pat_row,
  input  logic               emit_last,
  output seq_st_t            st,
  output logic               accept,
  output logic               vram_req,
  output logic [VA_W-1:0]    vram_addr,
  output logic               done
);
  localparam int IDX_W = $clog2(NSPR);
  localparam int CNT_W = $clog2(NSPR + 1);

  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] live_cnt;
  logic             rd_ok;
  logic             term_hit;
  logic             idx_top;
  logic             idx_zero;
  logic [VA_W-1:0]  ent_addr;
  logic             in_draw;

  assign rd_ok    = vram_req && vram_valid;
  assign term_hit = (vram_data == END_MARK);
  assign idx_top  = (idx == IDX_W'(NSPR - 1));
  assign idx_zero = (idx == '0);
  assign accept   = (st == ST_IDLE) && start;
  assign ent_addr = sat_base + VA_W'({idx, 2'b00});
  assign in_draw  = (st == ST_DY) || (st == ST_DX) || (st == ST_DN) || (st == ST_DC) ||
                    (st == ST_CHK) || (st == ST_PAT) || (st == ST_EMIT);

  always_comb begin
    vram_req  = 1'b0;
    vram_addr = '0;
    case (st)
      ST_CNT, ST_DY: begin vram_req = 1'b1; vram_addr = ent_addr; end
      ST_DX:  begin vram_req = 1'b1; vram_addr = ent_addr + VA_W'(1); end
      ST_DN:  begin vram_req = 1'b1; vram_addr = ent_addr + VA_W'(2); end
      ST_DC:  begin vram_req = 1'b1; vram_addr = ent_addr + VA_W'(3); end
      ST_PAT: begin
        vram_req  = 1'b1;
        vram_addr = pat_base + VA_W'({pat_name, 3'b000}) + VA_W'(pat_row);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      live_cnt <= '0;
      done     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st   <= ST_CNT;
          idx  <= '0;
          done <= 1'b0;
        end
        ST_CNT: if (rd_ok) begin
          if (term_hit) begin
            live_cnt <= CNT_W'(idx);
            if (idx_zero) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              idx <= idx - 1'b1;
              st  <= ST_DY;
            end
          end else if (idx_top) begin
            live_cnt <= CNT_W'(NSPR);
            st       <= ST_DY;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_DY:  if (rd_ok) st <= ST_DX;
        ST_DX:  if (rd_ok) st <= ST_DN;
        ST_DN:  if (rd_ok) st <= ST_DC;
        ST_DC:  if (rd_ok) st <= ST_CHK;
        ST_CHK: begin
          if (draw_ok) st <= ST_PAT;
          else if (idx_zero) begin st <= ST_IDLE; done <= 1'b1; end
          else begin idx <= idx - 1'b1; st <= ST_DY; end
        end
        ST_PAT: if (rd_ok) st <= ST_EMIT;
        ST_EMIT: if (emit_last) begin
          if (idx_zero) begin st <= ST_IDLE; done <= 1'b1; end
          else begin idx <= idx - 1'b1; st <= ST_DY; end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_req && !vram_valid) |=> (vram_req && $stable(vram_addr)));

  // R2
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CNT && rd_ok && !term_hit && !idx_top) |=>
      (st == ST_CNT && idx == $past(idx) + 1'b1));

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EMIT && emit_last && !idx_zero) |=>
      (st == ST_DY && idx == $past(idx) - 1'b1));

  // R5
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_draw |-> (CNT_W'(idx) < live_cnt));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !vram_req);

endmodule

// File: rtl/sls_attr.sv
module sls_attr
  import sls_pkg::*;
#(
  parameter int COL_W    = 4,
  parameter int SPR_ROWS = 8,
  parameter int ROW_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seq_st_t            st,
  input  logic               accept,
  input  logic [7:0]         scanline,
  input  logic [7:0]         vram_data,
  input  logic               vram_valid,
  output logic [7:0]         xpos,
  output logic [7:0]         pat_name,
  output logic [COL_W-1:0]   colour,
  output logic [ROW_W-1:0]   pat_row,
  output logic               draw_ok
);
  logic [7:0] line_q;
  logic [7:0] ypos;
  logic [7:0] row8;
  logic       on_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q   <= '0;
      ypos     <= '0;
      xpos     <= '0;
      pat_name <= '0;
      colour   <= '0;
    end else begin
      if (accept) line_q <= scanline;
      if (vram_valid) begin
        case (st)
          ST_DY: ypos     <= vram_data;
          ST_DX: xpos     <= vram_data;
          ST_DN: pat_name <= vram_data;
          ST_DC: colour   <= vram_data[COL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign row8    = row_of(line_q, ypos);
  assign on_line = (row8 < 8'(SPR_ROWS));
  assign pat_row = row8[ROW_W-1:0];
  assign draw_ok = on_line && (colour != '0);

  // R6
  row_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PAT) |-> (row_of(line_q, ypos) < 8'(SPR_ROWS)));

endmodule

// File: rtl/sls_emit.sv
module sls_emit
  import sls_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [7:0]         pat_byte,
  input  logic [7:0]         xpos,
  input  logic [COL_W-1:0]   colour,
  output logic               lb_we,
  output logic [7:0]         lb_addr,
  output logic [COL_W-1:0]   lb_color,
  output logic               emit_last
);
  logic [7:0] shreg;
  logic [2:0] pix;
  logic       busy;
  logic [8:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      pix   <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= pat_byte;
      pix   <= '0;
      busy  <= 1'b1;
    end else if (busy) begin
      shreg <= {shreg[6:0], 1'b0};
      pix   <= pix + 1'b1;
      if (pix == 3'd7) busy <= 1'b0;
    end
  end

  assign pos       = pix_pos(xpos, pix);
  assign lb_addr   = pos[7:0];
  assign lb_color  = colour;
  assign lb_we     = busy && shreg[7] && !pos[8] && (colour != '0);
  assign emit_last = busy && (pix == 3'd7);

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_we |-> (lb_addr >= xpos));

  // R7
  slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(emit_last));

endmodule

// File: rtl/sprite_line_seq.sv
module sprite_line_seq
  import sls_pkg::*;
#(
  parameter int NSPR     = 32,
  parameter int VA_W     = 14,
  parameter int COL_W    = 4,
  parameter int SPR_ROWS = 8,
  parameter logic [7:0] END_MARK = 8'hD0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [7:0]         scanline,
  input  logic [VA_W-1:0]    sat_base,
  input  logic [VA_W-1:0]    pat_base,
  output logic               vram_req,
  output logic [VA_W-1:0]    vram_addr,
  input  logic [7:0]         vram_data,
  input  logic               vram_valid,
  output logic               lb_we,
  output logic [7:0]         lb_addr,
  output logic [COL_W-1:0]   lb_color,
  output logic               done
);
  localparam int ROW_W = $clog2(SPR_ROWS);

  seq_st_t          st;
  logic             accept;
  logic             draw_ok;
  logic [7:0]       xpos;
  logic [7:0]       pat_name;
  logic [COL_W-1:0] colour;
  logic [ROW_W-1:0] pat_row;
  logic             emit_last;
  logic             pat_load;

  assign pat_load = (st == ST_PAT) && vram_valid;

  sls_ctrl #(.NSPR(NSPR), .VA_W(VA_W), .ROW_W(ROW_W), .END_MARK(END_MARK)) u_ctrl (
    .clk, .rst_n, .start, .sat_base, .pat_base, .vram_data, .vram_valid,
    .draw_ok, .pat_name, .pat_row, .emit_last,
    .st, .accept, .vram_req, .vram_addr, .done
  );

  sls_attr #(.COL_W(COL_W), .SPR_ROWS(SPR_ROWS), .ROW_W(ROW_W)) u_attr (
    .clk, .rst_n, .st, .accept, .scanline, .vram_data, .vram_valid,
    .xpos, .pat_name, .colour, .pat_row, .draw_ok
  );

  sls_emit #(.COL_W(COL_W)) u_emit (
    .clk, .rst_n, .load(pat_load), .pat_byte(vram_data), .xpos, .colour,
    .lb_we, .lb_addr, .lb_color, .emit_last
  );

  // R8
  opaque_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_we |-> (lb_color != '0));

  // R1
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!vram_req && !lb_we));

endmodule

// File: tb/sim_sprite_line_seq.sv
`timescale 1ns/1ps
module sim_sprite_line_seq;
  localparam logic [13:0] SAT = 14'h0200;
  localparam logic [13:0] PAT = 14'h0400;
  localparam logic [7:0]  ENDM = 8'hD0;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, vram_req, vram_valid, lb_we, done;
  logic [7:0]  scanline, vram_data, lb_addr;
  logic [13:0] vram_addr;
  logic [3:0]  lb_color;

  sprite_line_seq u0 (
    .clk, .rst_n, .start, .scanline, .sat_base(SAT), .pat_base(PAT),
    .vram_req, .vram_addr, .vram_data, .vram_valid,
    .lb_we, .lb_addr, .lb_color, .done
  );

  logic [7:0] mem [0:2047];
  int lb [0:255];
  int exp_lb [0:255];
  int cyc = 0, done_cyc = -1, last_we_cyc = -1, last_vld_cyc = -1;
  int first_seen = 0, hold_err = 0, pend = 0, lat = 0;
  int first_addr = 0;
  logic [13:0] paddr, prev_addr;
  logic prev_req = 1'b0;
  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor and video RAM model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (lb_we) begin lb[lb_addr] = lb_color; last_we_cyc = cyc; end
      if (done && done_cyc < 0) done_cyc = cyc;
      if (vram_req && !first_seen) begin first_addr = vram_addr; first_seen = 1; end
      if (prev_req && !vram_valid && (!vram_req || vram_addr != prev_addr)) hold_err++;
    end
    prev_req  = vram_req;
    prev_addr = vram_addr;
    vram_valid = 1'b0;
    if (pend != 0) begin
      lat--;
      if (lat == 0) begin
        vram_valid = 1'b1;
        vram_data  = mem[paddr[10:0]];
        pend = 0;
        last_vld_cyc = cyc;
      end
    end else if (rst_n && vram_req) begin
      pend  = 1;
      paddr = vram_addr;
      lat   = int'($urandom_range(1, 3));
    end
  end

  function automatic bit vis(input logic [7:0] ln, input logic [7:0] y);
    logic [7:0] r;
    r = ln - y - 8'd1;
    return r < 8;
  endfunction

  function automatic int ref_count();
    for (int i = 0; i < 32; i++)
      if (mem[11'(SAT + 4 * i)] == ENDM) return i;
    return 32;
  endfunction

  function automatic logic [7:0] pat_of(input int i, input logic [7:0] ln);
    logic [7:0] y, n, r;
    y = mem[11'(SAT + 4 * i)];
    n = mem[11'(SAT + 4 * i + 2)];
    r = ln - y - 8'd1;
    return mem[11'(PAT + 8 * n + r)];
  endfunction

  function automatic void build_exp(input logic [7:0] ln, input int cnt);
    for (int p = 0; p < 256; p++) exp_lb[p] = 16;
    for (int i = cnt - 1; i >= 0; i--) begin
      logic [7:0] y, x, b;
      logic [3:0] c;
      y = mem[11'(SAT + 4 * i)];
      x = mem[11'(SAT + 4 * i + 1)];
      c = mem[11'(SAT + 4 * i + 3)][3:0];
      if (vis(ln, y) && c != 0) begin
        b = pat_of(i, ln);
        for (int k = 0; k < 8; k++)
          if (b[7 - k] && (int'(x) + k) < 256) exp_lb[int'(x) + k] = c;
      end
    end
  endfunction

  task automatic set_spr(input int i, input logic [7:0] y, input logic [7:0] x,
                         input logic [7:0] n, input logic [7:0] c);
    mem[11'(SAT + 4 * i)]     = y;
    mem[11'(SAT + 4 * i + 1)] = x;
    mem[11'(SAT + 4 * i + 2)] = n;
    mem[11'(SAT + 4 * i + 3)] = c;
  endtask

  task automatic set_pat(input logic [7:0] n, input logic [7:0] b);
    for (int r = 0; r < 8; r++) mem[11'(PAT + 8 * n + r)] = b;
  endtask

  // every entry off the line and no marker
  task automatic blank_sat(input logic [7:0] ln);
    for (int i = 0; i < 32; i++) set_spr(i, ln + 8'd40, 8'd0, 8'd0, 8'd0);
  endtask

  task automatic run_scan(input string tag, input logic [7:0] ln);
    int t, cnt, mism, bad_p;
    logic [7:0] x0, y0;
    logic [3:0] c0;
    for (int p = 0; p < 256; p++) lb[p] = 16;
    last_we_cyc = -1;
    first_seen  = 0;
    @(negedge clk);
    scanline = ln;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    done_cyc = -1;
    t = 0;
    while (done_cyc < 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    cnt = ref_count();
    build_exp(ln, cnt);
    mism = 0; bad_p = 0;
    for (int p = 0; p < 256; p++)
      if (lb[p] != exp_lb[p]) begin
        if (mism == 0) bad_p = p;
        mism++;
      end
    check(done_cyc >= 0, {tag, " R10 done seen"}, done_cyc, 1);
    check(mism == 0, {tag, " line buffer"}, lb[bad_p], exp_lb[bad_p]);
    check(first_addr == int'(SAT), "R2 first read at table base", first_addr, int'(SAT));
    y0 = mem[11'(SAT)];
    x0 = mem[11'(SAT + 1)];
    c0 = mem[11'(SAT + 3)][3:0];
    if (cnt == 0)
      check(done_cyc == last_vld_cyc + 1, "R10 done after empty count", done_cyc, last_vld_cyc + 1);
    else if (vis(ln, y0) && c0 != 0 && pat_of(0, ln)[0] && x0 <= 8'd248)
      check(done_cyc == last_we_cyc + 1, "R10 done after last write", done_cyc, last_we_cyc + 1);
    else if (last_we_cyc >= 0)
      check(done_cyc > last_we_cyc, "R10 done after writes", done_cyc, last_we_cyc + 1);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed_v;
    logic [7:0] ln;
    seed_v = $urandom(32'd4242);
    rst_n = 1'b0; start = 1'b0; scanline = '0;
    vram_valid = 1'b0; vram_data = '0;
    for (int a = 0; a < 2048; a++) mem[a] = 8'($urandom);
    repeat (5) @(negedge clk);
    // R1 reset state
    check(!done && !vram_req && !lb_we, "R1 outputs low in reset", {done, vram_req, lb_we}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !vram_req && !lb_we, "R1 outputs low after reset", {done, vram_req, lb_we}, 0);

    // R3: marker at entry 0, visible sprites behind it
    ln = 8'd50;
    for (int i = 0; i < 32; i++) set_spr(i, 8'd47, 8'(i * 8), 8'(i), 8'h0F);
    mem[11'(SAT)] = ENDM;
    run_scan("R3 marker at entry 0", ln);

    // R2: no marker, all 32 visible and opaque
    for (int i = 0; i < 32; i++) set_spr(i, 8'd46, 8'(i * 7), 8'(i), 8'(1 + i % 15));
    for (int i = 0; i < 32; i++) set_pat(8'(i), 8'hFF);
    run_scan("R2 full table of 32", ln);

    // R4: stacked sprites, lowest number must win
    ln = 8'd90;
    blank_sat(ln);
    set_pat(8'd10, 8'hFF);
    set_spr(0, 8'd85, 8'd100, 8'd10, 8'd5);
    set_spr(1, 8'd86, 8'd100, 8'd10, 8'd6);
    set_spr(2, 8'd87, 8'd104, 8'd10, 8'd7);
    mem[11'(SAT + 12)] = ENDM;
    run_scan("R4 priority stack", ln);

    // R5: sprites above the marker are never drawn
    blank_sat(ln);
    set_spr(0, 8'd85, 8'd10, 8'd10, 8'd3);
    set_spr(1, 8'd85, 8'd30, 8'd10, 8'd4);
    mem[11'(SAT + 8)] = ENDM;
    for (int i = 3; i < 32; i++) set_spr(i, 8'd85, 8'(60 + i * 6), 8'd10, 8'd9);
    run_scan("R5 beyond marker", ln);

    // R6: row window edges
    ln = 8'd20;
    blank_sat(ln);
    set_spr(0, 8'd19, 8'd0,  8'd10, 8'd2);
    set_spr(1, 8'd12, 8'd20, 8'd10, 8'd3);
    set_spr(2, 8'd20, 8'd40, 8'd10, 8'd4);
    set_spr(3, 8'd11, 8'd60, 8'd10, 8'd5);
    mem[11'(SAT + 16)] = ENDM;
    run_scan("R6 row window edges", ln);
    ln = 8'd3;
    blank_sat(ln);
    set_spr(0, 8'd255, 8'd80, 8'd10, 8'd6);
    mem[11'(SAT + 4)] = ENDM;
    run_scan("R6 wrap from y=255", ln);

    // R7: bit order
    ln = 8'd40;
    blank_sat(ln);
    set_pat(8'd5, 8'h81);
    set_spr(0, 8'd39, 8'd120, 8'd5, 8'd11);
    mem[11'(SAT + 4)] = ENDM;
    run_scan("R7 pattern bit order", ln);

    // R8: transparent sprite 0 over opaque sprite 1
    blank_sat(ln);
    set_spr(0, 8'd36, 8'd50, 8'd10, 8'hF0);
    set_spr(1, 8'd36, 8'd50, 8'd10, 8'd9);
    mem[11'(SAT + 8)] = ENDM;
    run_scan("R8 colour 0 transparent", ln);

    // R9: right edge clip
    blank_sat(ln);
    set_spr(0, 8'd38, 8'd252, 8'd10, 8'd12);
    mem[11'(SAT + 4)] = ENDM;
    run_scan("R9 right edge clip", ln);

    // random tables: R4 R5 R6 R7 R8 R9 together
    for (int s = 0; s < 40; s++) begin
      int term;
      ln = 8'($urandom_range(0, 191));
      for (int i = 0; i < 32; i++) begin
        logic [7:0] y, x;
        if ($urandom_range(0, 3) == 0) y = 8'($urandom);
        else y = ln - 8'($urandom_range(0, 9));
        if (y == ENDM) y = 8'hD1;
        if ($urandom_range(0, 3) == 0) x = 8'($urandom_range(240, 255));
        else x = 8'($urandom);
        set_spr(i, y, x, 8'($urandom_range(0, 127)), 8'($urandom));
      end
      term = ($urandom_range(0, 1) == 0) ? int'($urandom_range(0, 31)) : 32;
      if (term < 32) mem[11'(SAT + 4 * term)] = ENDM;
      run_scan("R4 random table", ln);
    end

    // R11 handshake hold, seen at the ports across the whole run
    check(hold_err == 0, "R11 address held until valid", hold_err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule